// File: doc/BRIEF.md
# Pattern-Triggered Word Playback Unit

This block joins two 32-bit banks that share one sample strobe. An input bank is sampled on every strobe. Each sample is reduced through a mask and compared with a data word, using either an equal test or a not-equal test. When a sample newly meets the condition, the block raises a one-cycle trigger. The trigger starts an output bank that steps through a stored trace, one word per strobe, at the same rate as the input sampling.

The typical use is to stand in for a mechanical switch's position-confirm line. Software loads the trace with a run of idle words followed by active words. The number of idle words sets how many samples pass between the start of a drive pulse and the appearance of the confirm signal. Before a trigger, the output bank shows a programmable idle word. When the trace ends, the output keeps its last word and a done flag rises. A re-arm pulse then makes the unit ready for the next trigger.

Top module: `pattern_playback`

## Requirements
- R1: After reset, `dout` equals `idle_word`, and `trig`, `busy` and `done` are all 0.
- R2: With `cmp_type` 0 (equal), a sample matches when every input bit whose `cmp_mask` bit is 1 equals the corresponding `cmp_data` bit. Unmasked bits are ignored. For example, data FFFFFFFF with mask 00000001 matches whenever bit 0 is 1.
- R3: With `cmp_type` 1 (not-equal), a sample matches when at least one masked input bit differs from `cmp_data`.
- R4: Matches are evaluated only on clock edges where `strobe` is 1, and the previous-match history starts at 0 after reset. A trigger occurs only while armed, and only on a strobed sample that matches when the previous strobed sample did not. `trig` is then 1 for exactly the one cycle that follows that edge. A match that stays true does not trigger again.
- R5: Trace word 0 appears on `dout` after the triggering edge. Word i appears after the i-th following strobe edge. Between strobes, `dout` does not change.
- R6: While the unit is armed, `dout` follows `idle_word`.
- R7: The trace length is `trace_last`+1 words, sampled at the trigger. On the strobe after the last word is shown, `done` goes to 1 and `dout` keeps the last word.
- R8: While `done` is 1, matches are ignored. A 1 on `arm` returns the unit to armed. `arm` has no effect during playback.
- R9: On an edge where `wr_en` is 1, `wr_data` is stored at trace address `wr_addr`. A later playback outputs the stored value.
- R10: `busy` is 1 exactly while playback is running, and it is never 1 together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Sample strobe shared by both banks |
| din | input | 32 | Input bank word |
| cmp_data | input | 32 | Compare data word |
| cmp_mask | input | 32 | Compare mask, 1 = bit takes part |
| cmp_type | input | 1 | 0 = equal, 1 = not-equal |
| idle_word | input | 32 | Output value while armed |
| trace_last | input | 10 | Trace length minus one |
| arm | input | 1 | Re-arm after done |
| wr_en | input | 1 | Trace write enable |
| wr_addr | input | 10 | Trace write address |
| wr_data | input | 32 | Trace write data |
| dout | output | 32 | Output bank word |
| trig | output | 1 | One-cycle trigger pulse |
| busy | output | 1 | Playback running |
| done | output | 1 | Playback finished, awaiting arm |

## Verification
The bench targets several corner cases.

- **Held match after re-arm.** A unit that fired on level instead of edge would restart playback immediately.
- **Input pulse between strobes.** A design that compared without the strobe would trigger on it.
- **Arm during playback.** A design that honoured it would cut the trace short.
- **Match while done.** A design that ignored the done state would retrigger.
- **Trace length extremes.** A one-word trace and a full 1024-word trace would expose off-by-one end detection: a design that got it wrong would drop or repeat a word, or set `done` a strobe early or late.

Both compare types run with unmasked bits randomised, so a mask that was applied incorrectly would show up as a spurious trigger or a missing one.

// File: rtl/pattern_playback.sv
module pattern_playback #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strobe,
  input  logic [WIDTH-1:0]         din,
  input  logic [WIDTH-1:0]         cmp_data,
  input  logic [WIDTH-1:0]         cmp_mask,
  input  logic                     cmp_type,
  input  logic [WIDTH-1:0]         idle_word,
  input  logic [$clog2(DEPTH)-1:0] trace_last,
  input  logic                     arm,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  output logic [WIDTH-1:0]         dout,
  output logic                     trig,
  output logic                     busy,
  output logic                     done
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [1:0] {ST_ARMED, ST_PLAY, ST_FIN} st_t;

  st_t             st;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] out_q;
  logic [AW-1:0]    idx, last_q, nxt;
  logic             hit_q;

  wire eq   = ((din ^ cmp_data) & cmp_mask) == '0;
  wire hit  = cmp_type ? !eq : eq;
  wire fire = strobe && hit && !hit_q && (st == ST_ARMED);

  assign nxt  = idx + 1'b1;
  assign dout = (st == ST_ARMED) ? idle_word : out_q;
  assign busy = (st == ST_PLAY);
  assign done = (st == ST_FIN);

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_ARMED;
      hit_q  <= 1'b0;
      trig   <= 1'b0;
      idx    <= '0;
      last_q <= '0;
      out_q  <= '0;
    end else begin
      trig <= fire;
      if (strobe) hit_q <= hit;
      case (st)
        ST_ARMED:
          if (fire) begin
            st     <= ST_PLAY;
            idx    <= '0;
            last_q <= trace_last;
            out_q  <= mem[0];
          end
        ST_PLAY:
          if (strobe) begin
            if (idx == last_q) st <= ST_FIN;
            else begin
              idx   <= nxt;
              out_q <= mem[nxt];
            end
          end
        default:
          if (arm) st <= ST_ARMED;
      endcase
    end
  end
endmodule

module pattern_playback_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe,
  input logic [WIDTH-1:0] dout,
  input logic             trig,
  input logic             busy,
  input logic             done
);
  assert_trig_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  assert_trig_strobed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> $past(strobe));
  assert_hold_between_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(strobe)) |-> $stable(dout));
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(dout));
  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_trig_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> busy);
endmodule

bind pattern_playback pattern_playback_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .dout(dout),
  .trig(trig), .busy(busy), .done(done)
);

// File: tb/pattern_playback_bench.sv
module pattern_playback_bench;
  logic        clk = 0, rst_n = 0, strobe = 0, cmp_type = 0, arm = 0, wr_en = 0;
  logic [31:0] din = 0, cmp_data = 0, cmp_mask = 0, idle_word = 0, wr_data = 0;
  logic [9:0]  trace_last = 0, wr_addr = 0;
  logic [31:0] dout;
  logic        trig, busy, done;

  pattern_playback u_pattern_playback (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, ntrig = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  logic [31:0] mmem [1024];
  int          m_st = 0, m_idx = 0, m_last = 0;
  bit          m_hp = 0, m_trig = 0;
  logic [31:0] m_out = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_hp = 0; m_trig = 0; m_idx = 0; m_last = 0; m_out = 0;
    end else begin
      bit match, hit;
      match = 1;
      for (int b = 0; b < 32; b++)
        if (cmp_mask[b] && din[b] != cmp_data[b]) match = 0;
      hit = cmp_type ? !match : match;
      m_trig = 0;
      if (m_st == 0) begin
        if (strobe && hit && !m_hp) begin
          m_st = 1; m_idx = 0; m_last = trace_last; m_out = mmem[0]; m_trig = 1;
        end
      end else if (m_st == 1) begin
        if (strobe) begin
          if (m_idx == m_last) m_st = 2;
          else begin m_idx++; m_out = mmem[m_idx]; end
        end
      end else if (arm) m_st = 0;
      if (strobe) m_hp = hit;
      if (wr_en) mmem[wr_addr] = wr_data;
    end
  end

  always @(posedge clk) begin
    #6;
    if (rst_n) begin
      chk(dout == ((m_st == 0) ? idle_word : m_out), "R5 dout", dout, (m_st == 0) ? idle_word : m_out);
      chk(trig == m_trig, "R4 trig", {31'b0, trig}, {31'b0, m_trig});
      chk(done == (m_st == 2), "R7 done", {31'b0, done}, {31'b0, m_st == 2});
      chk(busy == (m_st == 1), "R10 busy", {31'b0, busy}, {31'b0, m_st == 1});
      if (trig) ntrig++;
    end
  end

  task automatic step(input logic s, input logic [31:0] d);
    @(posedge clk); #1;
    strobe = s; din = d; arm = 0; wr_en = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    strobe = 0; arm = 0; wr_en = 1; wr_addr = 10'(a); wr_data = d;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int t0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #6;
    chk(dout == 0 && !trig && !busy && !done, "R1 reset", {dout[28:0], trig, busy, done}, 0);

    for (int i = 0; i < 8; i++) wr(i, (i < 5) ? 32'h0 : (32'h100 | 32'(i)));
    trace_last = 7; cmp_data = 32'hFFFF_FFFF; cmp_mask = 32'h1; cmp_type = 0;
    t0 = ntrig;
    for (int i = 0; i < 10; i++) begin step(1, $urandom & ~32'h1); step(0, din); end
    for (int i = 0; i < 30; i++) begin
      step(1, $urandom | 32'h1);
      if (i == 3) arm = 1;
      step(0, din);
    end
    #5 chk(ntrig == t0 + 1, "R2 equal single trigger", ntrig, t0 + 1);
    chk(done == 1, "R8 arm during play ignored", {31'b0, done}, 1);
    chk(dout == 32'h107, "R7 last word held", dout, 32'h107);

    t0 = ntrig;
    for (int i = 0; i < 12; i++) step(1, 32'(i & 1));
    #5 chk(ntrig == t0, "R8 match ignored while done", ntrig, t0);

    step(1, 32'h1);
    idle_word = 32'hA5A5_A5A5; arm = 1;
    for (int i = 0; i < 10; i++) step(1, $urandom | 32'h1);
    #5 chk(dout == 32'hA5A5_A5A5, "R6 idle word while armed", dout, 32'hA5A5_A5A5);
    chk(ntrig == t0, "R4 held match no retrigger", ntrig, t0);

    step(1, 32'h0);
    step(0, 32'h1);
    step(0, 32'h0);
    step(1, 32'h0);
    step(1, 32'h0);
    #5 chk(ntrig == t0, "R4 unstrobed pulse ignored", ntrig, t0);

    wr(0, 32'hDEAD_BEEF);
    cmp_type = 1; cmp_data = 32'h0000_1234; cmp_mask = 32'h0000_FFFF; trace_last = 0;
    for (int i = 0; i < 6; i++) step(1, ($urandom & 32'hFFFF_0000) | 32'h1234);
    step(1, 32'h0000_123C);
    step(0, din);
    #5 chk(dout == 32'hDEAD_BEEF, "R9 written word played", dout, 32'hDEAD_BEEF);
    chk(ntrig == t0 + 1, "R3 not-equal trigger", ntrig, t0 + 1);
    step(1, din);
    step(0, din);
    #5 chk(done == 1, "R7 one-word trace done", {31'b0, done}, 1);

    arm = 1;
    step(0, 32'h0);
    for (int i = 0; i < 1024; i++) wr(i, 32'(i * 3 + 7));
    cmp_type = 0; cmp_data = 32'hFFFF_FFFF; cmp_mask = 32'h1; trace_last = 10'd1023;
    step(1, 32'h0);
    for (int i = 0; i < 1030; i++) step(1, 32'h1);
    #5 chk(done == 1 && dout == 32'(1023 * 3 + 7), "R7 full-depth trace", dout, 32'(1023 * 3 + 7));

    step(0, 32'h0);
    step(0, 32'h0);
    finish_run();
  end
endmodule